// File: doc/BRIEF.md
# Slow Infrared Pulse Codec

This block connects the serial data pins of a UART to an infrared transceiver and does the physical-layer pulse coding for slow infrared links. A 16-bit divisor divides the system clock to produce a sampling tick at sixteen times the bit rate. A phase counter groups these ticks into bit windows of sixteen. At the start of each window the block samples the transmit NRZ level. A low bit is sent as a short light pulse three ticks long. A high bit sends no pulse, and the line stays low between pulses.

On the receive side the transceiver output passes through an optional inverter and a two-flop synchronizer. The receive input can be switched off, and it is blanked automatically while the attached serializer reports that a frame is being sent. The receiver samples the cleaned signal on every tick. It reports a low bit for any window in which it saw the pulse on at least one tick, so the UART receiver gets a rebuilt NRZ stream one bit period late. The `bit_strobe` output marks each window boundary, and the serializer uses it to present its next bit. For a 48 MHz clock, the divisors 1250, 312, 156, 78, 52 and 26 give 2.4, 9.6, 19.2, 38.4, 57.6 and 115.2 kbit/s.

Top module: `irda_sir_codec`

## Requirements
- R1: With a constant non-zero divisor D, `bit_strobe` is high for one cycle every 16*D clock cycles.
- R2: A transmitted low bit makes `tx_pulse` high for exactly 3*D consecutive cycles, starting in the cycle that `bit_strobe` is high. A high bit leaves `tx_pulse` low for the whole window.
- R3: `tx_nrz` is sampled on the clock edge that raises `bit_strobe`. The pulse for that bit starts in the same cycle.
- R4: With `rx_pass_thru` = 0 (the reset-safe tie-off), the receiver treats a low level on `rx_ir` as a pulse. With `rx_pass_thru` = 1 it treats a high level as a pulse.
- R5: `rx_nrz` changes only when a window closes, that is in a cycle with `bit_strobe` high. It is 0 if the synchronized pulse was seen on any tick of the window just ended, and 1 otherwise.
- R6: While `tx_busy` is 1 the receiver ignores `rx_ir`. A window spent fully blanked reports 1.
- R7: While `rx_disable` is 1 the receiver ignores `rx_ir`. A window spent fully disabled reports 1.
- R8: A divisor of 0 stops the tick. From the next cycle on, `tx_pulse` = 0, `rx_nrz` = 1 and `bit_strobe` = 0, and the bit phase restarts at zero.
- R9: Writing a new non-zero divisor restarts the tick count in the next cycle, and the first tick comes D cycles after the restart. The bit phase is kept.
- R10: During reset `tx_pulse` = 0, `rx_nrz` = 1 and `bit_strobe` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clock cycles per 16x tick; 0 stops the block |
| tx_nrz | input | 1 | NRZ bit from the serializer (1 = idle/mark) |
| tx_busy | input | 1 | Serializer is sending; blanks the receiver |
| rx_ir | input | 1 | Receive line from the infrared transceiver |
| rx_pass_thru | input | 1 | 0: invert rx_ir, 1: use rx_ir as-is |
| rx_disable | input | 1 | 1 ignores rx_ir entirely |
| tx_pulse | output | 1 | Pulse drive to the infrared emitter |
| rx_nrz | output | 1 | Rebuilt NRZ bit stream for the UART receiver |
| bit_strobe | output | 1 | One-cycle marker at each bit window boundary |

## Verification
The modulator is driven with random bit streams and with runs of all-high bits. The random streams show that pulses appear only for low bits, always with the 3/16 width. The all-high runs show that idle windows really stay dark. The receiver is first fed back the transmit pulses through an inverting path and through a non-inverting path, with the matching polarity setting each time, so that one-bit-late recovery shows the polarity is handled correctly. A mismatched polarity setting then gives a stream of solid low bits. Random per-cycle noise on the receive line, together with blanking, disable, divisor values of 1, 2, 3 and 26, a divisor change in the middle of a bit and a divisor of zero, separates correct tick alignment and window closing from off-by-one errors in each counter.

// File: rtl/sir_pkg.sv
package sir_pkg;

   // Timing marks shared between the bit-phase tracker and the data paths.
   typedef struct packed {
      logic tick;     // one 16x sampling tick this cycle
      logic bit_end;  // the tick that closes a bit window
   } sir_timing_t;

   localparam int unsigned SIR_OVERSAMPLE_DEF = 16;
   localparam int unsigned SIR_PULSE_DEF      = 3;
   localparam int unsigned SIR_SYNC_DEF       = 2;

endpackage

// File: rtl/sir_tick_gen.sv
module sir_tick_gen #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_q;
   logic             run;
   logic             reload;
   logic             wrap;

   assign run    = (divisor != '0);
   assign reload = (divisor != div_q);
   assign wrap   = (cnt_q == divisor - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= '0;
         tick  <= 1'b0;
      end else begin
         div_q <= divisor;
         if (!run || reload) begin
            cnt_q <= '0;
            tick  <= 1'b0;
         end else if (wrap) begin
            cnt_q <= '0;
            tick  <= 1'b1;
         end else begin
            cnt_q <= cnt_q + DIV_W'(1);
            tick  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sir_bit_phase.sv
module sir_bit_phase
   import sir_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = SIR_OVERSAMPLE_DEF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        tick,
   output sir_timing_t tm,
   output logic        bit_strobe
);

   localparam int unsigned PH_W = $clog2(OVERSAMPLE);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

   logic [PH_W-1:0] ph_q;

   assign tm.tick    = tick;
   assign tm.bit_end = tick && (ph_q == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= '0;
         bit_strobe <= 1'b0;
      end else if (!en) begin
         ph_q       <= '0;
         bit_strobe <= 1'b0;
      end else if (tick) begin
         ph_q       <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
         bit_strobe <= (ph_q == PH_LAST);
      end else begin
         bit_strobe <= 1'b0;
      end
   end

endmodule

// File: rtl/sir_pulse_mod.sv
module sir_pulse_mod
   import sir_pkg::*;
#(
   parameter int unsigned PULSE_TICKS = SIR_PULSE_DEF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  sir_timing_t tm,
   input  logic        tx_nrz,
   output logic        tx_pulse
);

   localparam int unsigned PC_W = $clog2(PULSE_TICKS + 1);
   localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PULSE_TICKS);

   logic [PC_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (!en) begin
         left_q <= '0;
      end else if (tm.bit_end) begin
         left_q <= tx_nrz ? '0 : PC_LOAD;
      end else if (tm.tick && (left_q != '0)) begin
         left_q <= left_q - PC_W'(1);
      end
   end

   assign tx_pulse = (left_q != '0);

endmodule

// File: rtl/sir_pulse_demod.sv
module sir_pulse_demod
   import sir_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = SIR_SYNC_DEF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  sir_timing_t tm,
   input  logic        rx_ir,
   input  logic        rx_pass_thru,
   input  logic        rx_disable,
   input  logic        tx_busy,
   output logic        rx_nrz
);

   logic line_lvl;
   logic line_sync;
   logic pulse_now;
   logic seen_q;

   assign line_lvl = rx_pass_thru ? rx_ir : ~rx_ir;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign line_sync = line_lvl;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2+((SYNC_STAGES==1)?1:0):0] , line_lvl} >> ((SYNC_STAGES==1)?0:0);
         end
         assign line_sync = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   assign pulse_now = line_sync && !rx_disable && !tx_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         rx_nrz <= 1'b1;
      end else if (!en) begin
         seen_q <= 1'b0;
         rx_nrz <= 1'b1;
      end else if (tm.bit_end) begin
         rx_nrz <= ~(seen_q | pulse_now);
         seen_q <= 1'b0;
      end else if (tm.tick) begin
         seen_q <= seen_q | pulse_now;
      end
   end

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec
   import sir_pkg::*;
#(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned OVERSAMPLE  = SIR_OVERSAMPLE_DEF,
   parameter int unsigned PULSE_TICKS = SIR_PULSE_DEF,
   parameter int unsigned SYNC_STAGES = SIR_SYNC_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   input  logic             tx_nrz,
   input  logic             tx_busy,
   input  logic             rx_ir,
   input  logic             rx_pass_thru,
   input  logic             rx_disable,
   output logic             tx_pulse,
   output logic             rx_nrz,
   output logic             bit_strobe
);

   generate
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("OVERSAMPLE must be at least 2");
      end
      if (PULSE_TICKS < 1 || PULSE_TICKS >= OVERSAMPLE) begin : g_bad_pw
         $error("PULSE_TICKS must lie in 1..OVERSAMPLE-1");
      end
      if (DIV_W < 1) begin : g_bad_dw
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic        run;
   logic        tick;
   sir_timing_t tm;

   assign run = (divisor != '0);

   sir_tick_gen #(.DIV_W(DIV_W)) tick_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (divisor),
      .tick    (tick)
   );

   sir_bit_phase #(.OVERSAMPLE(OVERSAMPLE)) phase_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (run),
      .tick       (tick),
      .tm         (tm),
      .bit_strobe (bit_strobe)
   );

   sir_pulse_mod #(.PULSE_TICKS(PULSE_TICKS)) mod_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (run),
      .tm       (tm),
      .tx_nrz   (tx_nrz),
      .tx_pulse (tx_pulse)
   );

   sir_pulse_demod #(.SYNC_STAGES(SYNC_STAGES)) demod_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (run),
      .tm           (tm),
      .rx_ir        (rx_ir),
      .rx_pass_thru (rx_pass_thru),
      .rx_disable   (rx_disable),
      .tx_busy      (tx_busy),
      .rx_nrz       (rx_nrz)
   );

endmodule

// File: rtl/irda_sir_codec_chk.sv
module irda_sir_codec_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] divisor,
   input logic             tx_nrz,
   input logic             tx_pulse,
   input logic             rx_nrz,
   input logic             bit_strobe
);

   // R8
   zero_div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0) |=> (!tx_pulse && rx_nrz && !bit_strobe));

   // R3
   sample_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |-> (tx_pulse == !$past(tx_nrz)));

   // R2
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_pulse) |-> bit_strobe);

   // R5
   rx_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_strobe && ($past(divisor) != '0)) |-> $stable(rx_nrz));

   // R1
   strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |=> !bit_strobe);

endmodule

bind irda_sir_codec irda_sir_codec_chk #(.DIV_W(DIV_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .divisor    (divisor),
   .tx_nrz     (tx_nrz),
   .tx_pulse   (tx_pulse),
   .rx_nrz     (rx_nrz),
   .bit_strobe (bit_strobe)
);

// File: tb/irda_sir_codec_tb_top.sv
`timescale 1ns/1ps
module irda_sir_codec_tb_top;

   localparam int OS = 16;
   localparam int PW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] divisor = '0;
   logic        tx_nrz = 1'b1;
   logic        tx_busy = 1'b0;
   logic        rx_pass_thru = 1'b0;
   logic        rx_disable = 1'b0;
   logic        rx_drv = 1'b0;
   logic        loop_mode = 1'b1;
   logic        loop_inv = 1'b1;
   logic        tx_pulse, rx_nrz, bit_strobe;
   logic        rx_ir;

   always #2 clk = ~clk;

   assign rx_ir = loop_mode ? (loop_inv ? ~tx_pulse : tx_pulse) : rx_drv;

   irda_sir_codec dut_i (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .tx_nrz(tx_nrz),
      .tx_busy(tx_busy), .rx_ir(rx_ir), .rx_pass_thru(rx_pass_thru),
      .rx_disable(rx_disable), .tx_pulse(tx_pulse), .rx_nrz(rx_nrz),
      .bit_strobe(bit_strobe)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference: integer counters stepped once per clock.
   int m_cnt, m_divq, m_ph, m_pc;
   bit m_tick, m_strobe, m_rx, m_hit, m_s0, m_s1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_divq = 0; m_ph = 0; m_pc = 0;
         m_tick = 0; m_strobe = 0; m_rx = 1; m_hit = 0; m_s0 = 0; m_s1 = 0;
      end else begin
         int d;
         bit nt, p, e;
         d = int'(divisor);
         p = m_s1 && !rx_disable && !tx_busy;
         e = rx_pass_thru ? rx_ir : !rx_ir;
         nt = (d != 0) && (d == m_divq) && (m_cnt == d - 1);
         if (d == 0) begin
            m_ph = 0; m_pc = 0; m_hit = 0; m_rx = 1; m_strobe = 0;
         end else if (m_tick) begin
            if (m_ph == OS - 1) begin
               m_pc = tx_nrz ? 0 : PW;
               m_rx = !(m_hit || p);
               m_hit = 0;
               m_strobe = 1;
               m_ph = 0;
            end else begin
               if (m_pc > 0) m_pc = m_pc - 1;
               m_hit = m_hit || p;
               m_strobe = 0;
               m_ph = m_ph + 1;
            end
         end else begin
            m_strobe = 0;
         end
         if (d == 0 || d != m_divq || m_cnt == d - 1) m_cnt = 0;
         else m_cnt = m_cnt + 1;
         m_tick = nt;
         m_divq = d;
         m_s1 = m_s0;
         m_s0 = e;
      end
   end

   // Directed trackers, all evaluated at the falling edge.
   bit cmp_en = 0, int_chk = 0, pw_chk = 0, rec_chk = 0, blank_chk = 0, dark_chk = 0;
   bit tx_ones = 0;
   int cyc = 0, last_s = -1, run_len = 0, rec_n = 0, blank_n = 0, dark_n = 0;
   bit prev_bit = 1;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         if (cmp_en) begin
            chk(tx_pulse == (m_pc != 0), "R2 R3", "tx_pulse vs model", int'(tx_pulse), int'(m_pc != 0));
            chk(bit_strobe == m_strobe, "R1 R9", "bit_strobe vs model", int'(bit_strobe), int'(m_strobe));
            chk(rx_nrz == m_rx, "R4 R5 R6 R7", "rx_nrz vs model", int'(rx_nrz), int'(m_rx));
         end
         if (bit_strobe) begin
            if (int_chk && last_s >= 0)
               chk(cyc - last_s == OS * int'(divisor), "R1", "strobe interval", cyc - last_s, OS * int'(divisor));
            last_s = int_chk ? cyc : -1;
            if (rec_chk) begin
               if (rec_n >= 2) chk(rx_nrz == prev_bit, "R5", "recovered bit", int'(rx_nrz), int'(prev_bit));
               rec_n++;
            end else rec_n = 0;
            if (blank_chk) begin
               if (blank_n >= 2) chk(rx_nrz == 1'b1, "R6 R7", "ignored receive", int'(rx_nrz), 1);
               blank_n++;
            end else blank_n = 0;
            if (dark_chk) begin
               if (dark_n >= 2) chk(rx_nrz == 1'b0, "R4", "mismatched polarity", int'(rx_nrz), 0);
               dark_n++;
            end else dark_n = 0;
            prev_bit = tx_nrz;
            tx_nrz <= tx_ones ? 1'b1 : 1'($urandom_range(0, 1));
         end
         if (!int_chk) last_s = -1;
         if (tx_pulse) run_len++;
         else begin
            if (run_len > 0 && pw_chk)
               chk(run_len == PW * int'(divisor), "R2", "pulse width", run_len, PW * int'(divisor));
            run_len = 0;
         end
         if (!loop_mode) rx_drv <= 1'($urandom_range(0, 1));
      end
   end

   task automatic wait_bits(input int n);
      repeat (n) @(posedge clk iff bit_strobe);
      @(posedge clk); #1;
   endtask

   task automatic set_div(input int d);
      int_chk = 0; pw_chk = 0;
      divisor = 16'(d);
   endtask

   task automatic summary();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", "run expired", cyc, 0);
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R10: outputs during reset
      chk(tx_pulse == 1'b0, "R10", "tx_pulse in reset", int'(tx_pulse), 0);
      chk(rx_nrz == 1'b1, "R10", "rx_nrz in reset", int'(rx_nrz), 1);
      chk(bit_strobe == 1'b0, "R10", "bit_strobe in reset", int'(bit_strobe), 0);
      rst_n = 1'b1;
      cmp_en = 1;

      // inverting transceiver loop, matching default polarity
      set_div(3);
      wait_bits(2);
      int_chk = 1; pw_chk = 1; rec_chk = 1;
      wait_bits(40);

      // non-inverting loop with pass-through polarity
      rec_chk = 0;
      rx_pass_thru = 1; loop_inv = 0;
      wait_bits(1);
      rec_chk = 1;
      wait_bits(20);
      rec_chk = 0;

      // mismatched polarity: idle dark line looks like a pulse every window (R4)
      tx_ones = 1; loop_inv = 1;
      wait_bits(1);
      dark_chk = 1;
      wait_bits(6);
      dark_chk = 0; tx_ones = 0;

      // blanking while transmitting (R6)
      rx_pass_thru = 0;
      tx_busy = 1;
      blank_chk = 1;
      wait_bits(6);
      blank_chk = 0; tx_busy = 0;
      wait_bits(2);

      // receive disable (R7)
      rx_disable = 1;
      blank_chk = 1;
      wait_bits(6);
      blank_chk = 0; rx_disable = 0;
      rec_chk = 1;
      wait_bits(8);
      rec_chk = 0;

      // fastest divisor
      set_div(1);
      wait_bits(2);
      int_chk = 1; pw_chk = 1; rec_chk = 1;
      wait_bits(30);
      rec_chk = 0;

      // 115.2 kbit/s setting at 48 MHz
      set_div(26);
      wait_bits(2);
      int_chk = 1; pw_chk = 1; rec_chk = 1;
      wait_bits(5);
      rec_chk = 0;

      // divisor change in the middle of a bit (R9)
      set_div(3);
      wait_bits(1);
      repeat (17) @(posedge clk);
      #1;
      set_div(5);
      wait_bits(2);
      int_chk = 1; pw_chk = 1;
      wait_bits(6);

      // random noise on the receive line
      loop_mode = 0;
      set_div(2);
      wait_bits(12);
      loop_mode = 1;

      // divisor zero stops everything (R8)
      set_div(0);
      @(posedge clk); #1;
      @(posedge clk); #1;
      for (int i = 0; i < 40; i++) begin
         tx_nrz = i[0];
         loop_mode = 0;
         chk(tx_pulse == 1'b0, "R8", "tx_pulse stopped", int'(tx_pulse), 0);
         chk(rx_nrz == 1'b1, "R8", "rx_nrz stopped", int'(rx_nrz), 1);
         chk(bit_strobe == 1'b0, "R8", "bit_strobe stopped", int'(bit_strobe), 0);
         @(posedge clk); #1;
      end
      loop_mode = 1;

      // restart after stop: phase begins at zero, first strobe after 16*D cycles
      set_div(4);
      wait_bits(2);
      int_chk = 1; pw_chk = 1; rec_chk = 1;
      wait_bits(10);
      summary();
   end

endmodule